// File: doc/BRIEF.md
# Banked Rotate Execution Unit

This unit carries out two single-byte rotate instructions for an 8-bit core whose data memory is split into 256-byte banks. A 16-bit instruction word is offered on a valid/ready channel. Once it is taken, the unit runs a fixed four-phase sequence. It decodes the word and works out the physical address. It reads the addressed byte and rotates it. It then writes the result to the working register or back into data memory, and updates the carry, negative and zero flags.

The file address is eight bits wide. A mode bit in the instruction chooses how the bank is found. In banked mode the bank number comes from the bank select input. In access mode that input is ignored: the lower half of the address space lands in bank 0 and the upper half lands in the highest bank. The instruction channel takes no new word until the current one has finished. A one-cycle `done` pulse marks the cycle in which all results are visible. A host port preloads and reads the data RAM and preloads the working register and carry while the unit is idle.

Top module: `rot_exec_unit`

## Requirements
- R1: Bits [15:10] = 6'b010001 select rotate-left (carry not involved), and 6'b001100 select rotate-right-through-carry. Bit 9 is the destination select, bit 8 is the bank-mode bit, and bits [7:0] are the file address f.
- R2: Rotate-left gives {v[6:0], v[7]} for the operand byte v.
- R3: Rotate-right-through-carry gives {C, v[7:1]} for the old carry C, and the new carry becomes v[0].
- R4: Rotate-left leaves the carry flag unchanged.
- R5: After either rotate, N equals bit 7 of the result, and Z is 1 exactly when the result is 8'h00.
- R6: With bit 9 = 0 the result goes to W and the data RAM is unchanged. With bit 9 = 1 the result is written to the RAM location it was read from, and W is unchanged.
- R7: With bit 8 = 0, f < 8'h80 addresses bank 0 and f >= 8'h80 addresses the highest bank (all ones). `bank_sel` has no effect.
- R8: With bit 8 = 1, the physical address is {bank_sel, f}.
- R9: Any other value of bits [15:10] is a no-op: W, the flags and the RAM are unchanged, and `done` still pulses.
- R10: `instr_ready` is 1 only while idle. A word is taken on a clock edge with `instr_valid` and `instr_ready` both high. `done` is high for exactly one cycle, four cycles after the cycle in which the word was taken. Results are visible while `done` is high.
- R11: While idle, host writes to the RAM, W and C take effect on the next edge. `host_mem_rdata` shows the byte at `host_mem_addr` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_ready | output | 1 | Unit idle, will take a word |
| instr_word | input | 16 | Instruction word |
| bank_sel | input | BANK_BITS | Bank select, sampled when the word is taken |
| done | output | 1 | One-cycle completion pulse |
| w_out | output | 8 | Working register |
| flag_c | output | 1 | Carry flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| host_mem_we | input | 1 | Host RAM write strobe (idle only) |
| host_mem_addr | input | BANK_BITS+8 | Host RAM address |
| host_mem_wdata | input | 8 | Host RAM write data |
| host_mem_rdata | output | 8 | Host RAM read data |
| host_w_we | input | 1 | Host W load strobe (idle only) |
| host_w_wdata | input | 8 | Host W load value |
| host_c_we | input | 1 | Host carry load strobe (idle only) |
| host_c_wdata | input | 1 | Host carry load value |

## Verification
The assertions check on every cycle the handshake rules. Ready falls only when a word is taken, `done` follows exactly four cycles later, and it never lasts two cycles. They also check that N and Z agree with the byte just written, that the carry holds through a left rotate, that W holds when the result goes to the file, and that a no-op changes nothing. The bench has to show the rotate arithmetic and the carry chain. It also has to show the address mapping in both bank modes, and that the RAM location outside the selected one stays untouched. Only sweeps over operand values, carry-in, destination, bank mode and bank number can show those.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic [1:0] {OP_NOP, OP_ROL, OP_RRC} op_kind_t;
  typedef enum logic [2:0] {PH_IDLE, PH_Q1, PH_Q2, PH_Q3, PH_Q4} phase_t;

  localparam logic [5:0] ROL_CODE = 6'b010001;
  localparam logic [5:0] RRC_CODE = 6'b001100;

  typedef struct packed {
    op_kind_t   kind;
    logic       to_file;
    logic       banked;
    logic [7:0] faddr;
  } dec_t;
endpackage

// File: rtl/rot_decode.sv
module rot_decode
  import rot_pkg::*;
#(
  parameter int BANK_BITS = 3,
  localparam int PA = BANK_BITS + 8
) (
  input  logic [15:0]          iw,
  input  logic [BANK_BITS-1:0] bank,
  output dec_t                 dec,
  output logic [PA-1:0]        phys
);
  localparam logic [BANK_BITS-1:0] TOP_BANK = '1;
  localparam logic [BANK_BITS-1:0] LOW_BANK = '0;

  always_comb begin
    case (iw[15:10])
      ROL_CODE: dec.kind = OP_ROL;
      RRC_CODE: dec.kind = OP_RRC;
      default:  dec.kind = OP_NOP;
    endcase
    dec.to_file = iw[9];
    dec.banked  = iw[8];
    dec.faddr   = iw[7:0];
  end

  always_comb begin
    if (dec.banked)        phys = {bank, dec.faddr};
    else if (dec.faddr[7]) phys = {TOP_BANK, dec.faddr};
    else                   phys = {LOW_BANK, dec.faddr};
  end
endmodule

// File: rtl/rot_alu.sv
module rot_alu
  import rot_pkg::*;
(
  input  op_kind_t   kind,
  input  logic [7:0] opnd,
  input  logic       cin,
  output logic [7:0] res,
  output logic       cout,
  output logic       neg,
  output logic       zero
);
  always_comb begin
    res  = opnd;
    cout = cin;
    case (kind)
      OP_ROL: res = {opnd[6:0], opnd[7]};
      OP_RRC: begin
        res  = {cin, opnd[7:1]};
        cout = opnd[0];
      end
      default: ;
    endcase
  end

  assign neg  = res[7];
  assign zero = (res == 8'h00);
endmodule

// File: rtl/rot_ram.sv
module rot_ram #(
  parameter int AW = 11,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [7:0]    core_wdata,
  output logic [7:0]    core_rdata,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (core_we)      mem[core_addr] <= core_wdata;
    else if (host_we) mem[host_addr] <= host_wdata;
  end

  assign core_rdata = mem[core_addr];
  assign host_rdata = mem[host_addr];
endmodule

// File: rtl/rot_exec_unit.sv
module rot_exec_unit
  import rot_pkg::*;
#(
  parameter int BANK_BITS = 3,
  localparam int PA = BANK_BITS + 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  output logic                 instr_ready,
  input  logic [15:0]          instr_word,
  input  logic [BANK_BITS-1:0] bank_sel,
  output logic                 done,
  output logic [7:0]           w_out,
  output logic                 flag_c,
  output logic                 flag_n,
  output logic                 flag_z,
  input  logic                 host_mem_we,
  input  logic [PA-1:0]        host_mem_addr,
  input  logic [7:0]           host_mem_wdata,
  output logic [7:0]           host_mem_rdata,
  input  logic                 host_w_we,
  input  logic [7:0]           host_w_wdata,
  input  logic                 host_c_we,
  input  logic                 host_c_wdata
);
  phase_t               ph;
  logic [15:0]          instr_q;
  logic [BANK_BITS-1:0] bank_q;
  dec_t                 dec_w, dec_q;
  logic [PA-1:0]        phys_w, phys_q;
  logic [7:0]           opnd_q, res_q, core_rdata, alu_res;
  logic                 c_q, n_q, z_q, alu_c, alu_n, alu_z;
  logic                 core_we, idle, upd;

  assign idle        = (ph == PH_IDLE);
  assign instr_ready = idle;
  assign upd         = (ph == PH_Q4) && (dec_q.kind != OP_NOP);
  assign core_we     = upd && dec_q.to_file;

  rot_decode #(.BANK_BITS(BANK_BITS)) u_dec (
    .iw(instr_q), .bank(bank_q), .dec(dec_w), .phys(phys_w)
  );

  rot_alu u_alu (
    .kind(dec_q.kind), .opnd(opnd_q), .cin(flag_c),
    .res(alu_res), .cout(alu_c), .neg(alu_n), .zero(alu_z)
  );

  rot_ram #(.AW(PA)) u_ram (
    .clk(clk),
    .core_we(core_we), .core_addr(phys_q), .core_wdata(res_q), .core_rdata(core_rdata),
    .host_we(host_mem_we && idle), .host_addr(host_mem_addr),
    .host_wdata(host_mem_wdata), .host_rdata(host_mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      instr_q <= '0;
      bank_q  <= '0;
      dec_q   <= '0;
      phys_q  <= '0;
      opnd_q  <= '0;
      res_q   <= '0;
      c_q     <= 1'b0;
      n_q     <= 1'b0;
      z_q     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= (ph == PH_Q4);
      case (ph)
        PH_IDLE: if (instr_valid) begin
          instr_q <= instr_word;
          bank_q  <= bank_sel;
          ph      <= PH_Q1;
        end
        PH_Q1: begin
          dec_q  <= dec_w;
          phys_q <= phys_w;
          ph     <= PH_Q2;
        end
        PH_Q2: begin
          opnd_q <= core_rdata;
          ph     <= PH_Q3;
        end
        PH_Q3: begin
          res_q <= alu_res;
          c_q   <= alu_c;
          n_q   <= alu_n;
          z_q   <= alu_z;
          ph    <= PH_Q4;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_out  <= '0;
      flag_c <= 1'b0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else if (upd) begin
      if (!dec_q.to_file) w_out <= res_q;
      flag_c <= c_q;
      flag_n <= n_q;
      flag_z <= z_q;
    end else if (idle) begin
      if (host_w_we) w_out  <= host_w_wdata;
      if (host_c_we) flag_c <= host_c_wdata;
    end
  end
endmodule

// File: rtl/rot_exec_checker.sv
module rot_exec_checker
  import rot_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       instr_ready,
  input logic       done,
  input logic [7:0] w_out,
  input logic       flag_c,
  input logic       flag_n,
  input logic       flag_z,
  input op_kind_t   kind,
  input logic       to_file,
  input logic [7:0] file_q
);
  logic [7:0] written;
  assign written = to_file ? file_q : w_out;

  a_r10_accept_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(instr_ready) |-> ##4 done);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> instr_ready);
  a_r4_rol_holds_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == OP_ROL) |-> flag_c == $past(flag_c));
  a_r5_flags_track_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind != OP_NOP) |-> (flag_n == written[7] && flag_z == (written == 8'h00)));
  a_r6_w_held_on_file_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (done && to_file) |-> $stable(w_out));
  a_r9_nop_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == OP_NOP) |-> ($stable(w_out) && $stable({flag_c, flag_n, flag_z})));
endmodule

bind rot_exec_unit rot_exec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .instr_ready(instr_ready), .done(done),
  .w_out(w_out), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z),
  .kind(dec_q.kind), .to_file(dec_q.to_file), .file_q(core_rdata)
);

// File: tb/sim_rot_exec_unit.sv
module sim_rot_exec_unit;
  localparam int BB = 3;
  localparam int PA = BB + 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic instr_valid = 1'b0, instr_ready;
  logic [15:0] instr_word = '0;
  logic [BB-1:0] bank_sel = '0;
  logic done;
  logic [7:0] w_out;
  logic flag_c, flag_n, flag_z;
  logic host_mem_we = 1'b0;
  logic [PA-1:0] host_mem_addr = '0;
  logic [7:0] host_mem_wdata = '0, host_mem_rdata;
  logic host_w_we = 1'b0, host_c_we = 1'b0, host_c_wdata = 1'b0;
  logic [7:0] host_w_wdata = '0;

  int vectors = 0, fails = 0, cycles = 0;

  always #10 clk = ~clk;

  rot_exec_unit #(.BANK_BITS(BB)) u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mem_wr(input logic [PA-1:0] a, input logic [7:0] d);
    host_mem_we = 1'b1; host_mem_addr = a; host_mem_wdata = d;
    @(negedge clk);
    host_mem_we = 1'b0;
  endtask

  task automatic mem_rd(input logic [PA-1:0] a, output logic [7:0] d);
    host_mem_addr = a;
    #1 d = host_mem_rdata;
  endtask

  task automatic preload(input logic [7:0] w, input logic c);
    host_w_we = 1'b1; host_w_wdata = w; host_c_we = 1'b1; host_c_wdata = c;
    @(negedge clk);
    host_w_we = 1'b0; host_c_we = 1'b0;
  endtask

  // issue one word, return number of negedges until done (R10 expects 4)
  task automatic issue(input logic [15:0] iw, input logic [BB-1:0] b, output int n);
    instr_word = iw; bank_sel = b; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    bank_sel = ~b;
    n = 0;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic [PA-1:0] phys(input logic a, input logic [7:0] f, input logic [BB-1:0] b);
    if (a) return {b, f};
    return f[7] ? {{BB{1'b1}}, f} : {{BB{1'b0}}, f};
  endfunction

  initial begin
    int lim;
    lim = 150000;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > lim) begin
        check(1'b0, "watchdog", cycles, lim);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] vals [8] = '{8'h00, 8'h80, 8'h01, 8'hFF, 8'hAB, 8'hE6, 8'h7F, 8'h55};
    logic [7:0] rd, exp_r;
    logic exp_c;
    int n;

    repeat (3) @(negedge clk);
    // reset state (R10)
    check(instr_ready === 1'b1 && done === 1'b0, "R10 reset ready/done", {instr_ready, done}, 2);
    check(w_out === 8'h00 && {flag_c, flag_n, flag_z} === 3'b000, "R10 reset W/flags",
          {w_out, flag_c, flag_n, flag_z}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // host port (R11)
    mem_wr(11'h5C3, 8'h3C);
    mem_rd(11'h5C3, rd);
    check(rd === 8'h3C, "R11 host ram", rd, 8'h3C);
    preload(8'h96, 1'b1);
    check(w_out === 8'h96 && flag_c === 1'b1, "R11 host W/C", {w_out, flag_c}, {8'h96, 1'b1});

    // document examples (R2, R3)
    mem_wr(phys(1'b0, 8'h10, '0), 8'hAB);
    issue({6'b010001, 1'b1, 1'b0, 8'h10}, 3'd5, n);
    mem_rd(phys(1'b0, 8'h10, '0), rd);
    check(rd === 8'h57, "R2 example rotate-left", rd, 8'h57);
    mem_wr(phys(1'b0, 8'h11, '0), 8'hE6);
    preload(8'h00, 1'b0);
    issue({6'b001100, 1'b0, 1'b0, 8'h11}, 3'd2, n);
    check(w_out === 8'h73 && flag_c === 1'b0, "R3 example rotate-right", {w_out, flag_c}, {8'h73, 1'b0});

    // sweep: op, destination, bank mode, carry in, operand value
    for (int op = 0; op < 2; op++)
      for (int d = 0; d < 2; d++)
        for (int a = 0; a < 2; a++)
          for (int ci = 0; ci < 2; ci++)
            for (int vi = 0; vi < 8; vi++) begin
              logic [7:0] v, f;
              logic [BB-1:0] b;
              logic [PA-1:0] pa, other;
              logic [15:0] iw;
              v = vals[vi];
              f = 8'(vi * 41 + d * 150 + ci * 7 + op * 3);
              b = BB'(vi + d + 2 * a + 1);
              pa = phys(a[0], f, b);
              other = phys(~a[0], f, b);
              if (other == pa) other = pa ^ {1'b1, {(PA-1){1'b0}}};
              if (op == 0) begin exp_r = {v[6:0], v[7]}; exp_c = ci[0]; end
              else begin exp_r = {ci[0], v[7:1]}; exp_c = v[0]; end
              iw = {(op == 0) ? 6'b010001 : 6'b001100, d[0], a[0], f};
              mem_wr(pa, v);
              mem_wr(other, ~v);
              preload(8'hC5, ci[0]);
              issue(iw, b, n);
              check(n == 4, "R10 latency", n, 4);
              if (d == 0) begin
                check(w_out === exp_r, (op == 0) ? "R2 rol to W (R6)" : "R3 rrc to W (R6)", w_out, exp_r);
                mem_rd(pa, rd);
                check(rd === v, "R6 file kept when dest W", rd, v);
              end else begin
                mem_rd(pa, rd);
                check(rd === exp_r, (op == 0) ? "R2 rol to file (R6)" : "R3 rrc to file (R6)", rd, exp_r);
                check(w_out === 8'hC5, "R6 W kept when dest file", w_out, 8'hC5);
              end
              mem_rd(other, rd);
              check(rd === ~v, (a == 0) ? "R7 access bank ignores bank_sel" : "R8 banked address", rd, ~v);
              check(flag_c === exp_c, (op == 0) ? "R4 carry held" : "R3 carry out", flag_c, exp_c);
              check(flag_n === exp_r[7] && flag_z === (exp_r == 8'h00), "R5 N/Z",
                    {flag_n, flag_z}, {exp_r[7], exp_r == 8'h00});
            end

    // no-op opcodes (R9, R1)
    for (int k = 0; k < 3; k++) begin
      logic [15:0] iw;
      iw = (k == 0) ? 16'hFF22 : (k == 1) ? {6'b010000, 2'b10, 8'h22} : {6'b001101, 2'b11, 8'h22};
      mem_wr(phys(1'b0, 8'h22, '0), 8'h00);
      mem_wr({3'd1, 8'h22}, 8'h00);
      preload(8'h81, 1'b1);
      issue(iw, 3'd1, n);
      check(n == 4, "R9 no-op done", n, 4);
      check(w_out === 8'h81 && flag_c === 1'b1, "R9 no-op W/C kept", {w_out, flag_c}, {8'h81, 1'b1});
      mem_rd(phys(1'b0, 8'h22, '0), rd);
      check(rd === 8'h00, "R9 no-op RAM kept", rd, 0);
      mem_rd({3'd1, 8'h22}, rd);
      check(rd === 8'h00, "R9 no-op banked RAM kept", rd, 0);
    end

    // host write while busy is ignored (R11)
    mem_wr(11'h033, 8'h44);
    instr_word = {6'b010001, 2'b10, 8'h33}; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    host_w_we = 1'b1; host_w_wdata = 8'h11;
    @(negedge clk);
    host_w_we = 1'b0;
    while (!done) @(negedge clk);
    mem_rd(11'h033, rd);
    check(rd === 8'h88, "R11 busy host write ignored, R2 result", rd, 8'h88);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule